// File: doc/BRIEF.md
# Quad Wiper Register Command Executor

This block sits behind a two-wire bus slave and carries out the register operations of a four-channel digital potentiometer. Each channel owns one volatile 6-bit wiper position and a bank of four 6-bit data registers. The data registers stand in for nonvolatile cells. The slave hands over the instruction byte and the optional data byte as one-cycle strobes, and it reports start and stop conditions as pulses. The block answers with read data, a per-channel wiper-load pulse and a busy flag. The slave uses the busy flag to withhold its acknowledge while a modelled store is in progress.

Writes that only touch a wiper take effect at once. Anything that changes a data register is held until the stop condition arrives directly after the command. The write-protect input is sampled at that stop. The store then opens a busy window whose length is set by a parameter. Reset stands for power-up: each data register takes a computed initial value, and in the first cycle after reset every wiper is reloaded from its channel's data register 0.

Top module: `qpot_cmd_exec`

## Requirements
- R1: Reset initialises data register r of channel p to (DR_BASE + 5*p + r) mod 64. Busy is high in the first cycle after reset. In that cycle each wiper is loaded from its own data register 0, so the loaded value is visible in the following cycle.
- R2: The instruction byte carries the opcode in bits [7:4], the register index in [3:2] and the channel index in [1:0]. Opcode 1001 returns the selected wiper on rd_data, with rd_valid high in the cycle after cmd_valid.
- R3: Opcode 1010 followed by a data byte writes that value to the selected wiper. In the next cycle, wiper_load is high for that channel only.
- R4: Opcode 1011 returns data register [3:2] of channel [1:0] on rd_data in the cycle after cmd_valid.
- R5: Opcode 1100 followed by a data byte and then a stop writes the data register. Busy then stays high for exactly WR_CYCLES cycles, starting in the cycle after the stop.
- R6: Opcode 1101 copies the selected data register into that channel's wiper at once. Opcode 1110 stores that channel's wiper into data register [3:2], taking effect at the following stop.
- R7: Opcode 0001 copies data register [3:2] of every channel into its own wiper at once. Opcode 1000 stores every wiper into its data register [3:2] at the following stop.
- R8: Opcode 0010 puts the selected channel into step mode. Each step strobe then moves its wiper by one, up or down, saturating at 0 and 63. Step strobes have no effect once a start or stop has been seen.
- R9: When wp_n is low at the stop, a pending data-register write is dropped and busy stays low. Wiper writes still take effect.
- R10: A start condition or a data byte that arrives before the stop discards a pending data-register change.
- R11: While busy is high, command, data, stop and step strobes are ignored: there is no read data, no wiper change and no store.
- R12: Opcodes 0000, 0011 to 0111 and 1111 produce no read data, no wiper change and no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; models power-up |
| cmd_valid | input | 1 | Instruction byte strobe |
| cmd_byte | input | 8 | Instruction byte: opcode, register index, channel index |
| dat_valid | input | 1 | Data byte strobe |
| dat_val | input | 6 | Data value; the slave drops the two zero pad bits |
| step_valid | input | 1 | One step strobe in step mode |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| start_seen | input | 1 | Start condition pulse |
| stop_seen | input | 1 | Stop condition pulse |
| wp_n | input | 1 | Active-low write protect for data registers |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 6 | Read value for the slave to send |
| busy | output | 1 | Recall or store in progress |
| wiper_pos | output | 24 | Four wiper positions, channel p at [6p+5:6p] |
| wiper_load | output | 4 | Per-channel pulse when a wiper was loaded |

## Verification
The bench builds the block with WR_CYCLES = 20. This lets the whole store window be counted cycle by cycle, and lets strobes be injected inside it to show they are ignored. DR_BASE = 60 makes the computed initial values of the higher channels wrap past 63. As a result, the recall and read-back checks see values that a plain index pattern would not produce. Every wiper test starts from a value set on purpose, close to both saturation limits.

// File: rtl/qpot_pkg.sv
package qpot_pkg;
    localparam int POT_N = 4;
    localparam int REG_N = 4;
    localparam int WB    = 6;
    localparam int PW    = $clog2(POT_N);
    localparam int RW    = $clog2(REG_N);

    typedef logic [WB-1:0] pos_t;

    localparam logic [3:0] OPC_GLOAD  = 4'b0001;
    localparam logic [3:0] OPC_STEP   = 4'b0010;
    localparam logic [3:0] OPC_GSTORE = 4'b1000;
    localparam logic [3:0] OPC_RDW    = 4'b1001;
    localparam logic [3:0] OPC_WRW    = 4'b1010;
    localparam logic [3:0] OPC_RDD    = 4'b1011;
    localparam logic [3:0] OPC_WRD    = 4'b1100;
    localparam logic [3:0] OPC_LOAD   = 4'b1101;
    localparam logic [3:0] OPC_STORE  = 4'b1110;

    typedef enum logic [1:0] {PK_NONE, PK_VALUE, PK_WIPER} pend_kind_e;

    typedef struct packed {
        logic          rd_w;
        logic          wr_w;
        logic          rd_d;
        logic          wr_d;
        logic          load;
        logic          store;
        logic          gload;
        logic          gstore;
        logic          step;
        logic [RW-1:0] ri;
        logic [PW-1:0] pi;
    } cmd_t;

    function automatic cmd_t decode(input logic [7:0] b);
        cmd_t c;
        c    = '0;
        c.ri = b[3:2];
        c.pi = b[1:0];
        case (b[7:4])
            OPC_RDW:    c.rd_w   = 1'b1;
            OPC_WRW:    c.wr_w   = 1'b1;
            OPC_RDD:    c.rd_d   = 1'b1;
            OPC_WRD:    c.wr_d   = 1'b1;
            OPC_LOAD:   c.load   = 1'b1;
            OPC_STORE:  c.store  = 1'b1;
            OPC_GLOAD:  c.gload  = 1'b1;
            OPC_GSTORE: c.gstore = 1'b1;
            OPC_STEP:   c.step   = 1'b1;
            default:    ;
        endcase
        return c;
    endfunction

    function automatic pos_t init_val(input pos_t base, input int p, input int r);
        return base + pos_t'(5 * p + r);
    endfunction

    function automatic pos_t step_sat(input pos_t w, input logic up);
        if (up)
            return (w == '1) ? w : w + 1'b1;
        return (w == '0) ? w : w - 1'b1;
    endfunction
endpackage

// File: rtl/qpot_chan.sv
module qpot_chan
    import qpot_pkg::*;
#(
    parameter int   PIDX = 0,
    parameter pos_t BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              recall_i,
    input  logic              wl_en_i,
    input  pos_t              wl_val_i,
    input  logic              step_en_i,
    input  logic              step_up_i,
    input  logic              dr_we_i,
    input  logic [RW-1:0]     dr_sel_i,
    input  pos_t              dr_val_i,
    output pos_t              wiper_o,
    output pos_t [REG_N-1:0]  dr_o,
    output logic              wload_o
);
    pos_t             wiper_q;
    pos_t [REG_N-1:0] dr_q;
    logic             wload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper_q <= '0;
            wload_q <= 1'b0;
        end else begin
            wload_q <= recall_i | wl_en_i | step_en_i;
            if (recall_i)
                wiper_q <= dr_q[0];
            else if (wl_en_i)
                wiper_q <= wl_val_i;
            else if (step_en_i)
                wiper_q <= step_sat(wiper_q, step_up_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < REG_N; r++)
                dr_q[r] <= init_val(BASE, PIDX, r);
        end else if (dr_we_i) begin
            dr_q[dr_sel_i] <= dr_val_i;
        end
    end

    assign wiper_o = wiper_q;
    assign dr_o    = dr_q;
    assign wload_o = wload_q;
endmodule

// File: rtl/qpot_nvtimer.sv
module qpot_nvtimer #(
    parameter int WR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= CW'(WR_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/qpot_cmd_exec.sv
module qpot_cmd_exec
    import qpot_pkg::*;
#(
    parameter int   WR_CYCLES = 1000,
    parameter pos_t DR_BASE   = 6'd32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_byte,
    input  logic                dat_valid,
    input  logic [WB-1:0]       dat_val,
    input  logic                step_valid,
    input  logic                step_up,
    input  logic                start_seen,
    input  logic                stop_seen,
    input  logic                wp_n,
    output logic                rd_valid,
    output logic [WB-1:0]       rd_data,
    output logic                busy,
    output logic [POT_N*WB-1:0] wiper_pos,
    output logic [POT_N-1:0]    wiper_load
);
    cmd_t dc;
    logic recall_q, tmr_busy;
    logic acc_cmd, acc_dat, acc_stop, acc_step, commit;

    logic          cur_v, cur_wrw, cur_wrd;
    logic [PW-1:0] cur_pi;
    logic [RW-1:0] cur_ri;
    logic          step_on;
    logic [PW-1:0] step_pi;

    pend_kind_e       pend_kind;
    logic [POT_N-1:0] pend_mask;
    logic [RW-1:0]    pend_ri;
    pos_t             pend_val;

    pos_t             wip [POT_N];
    pos_t [REG_N-1:0] drs [POT_N];
    logic [POT_N-1:0] wl_en, step_en, dr_we, wload;
    pos_t             wl_val [POT_N];
    pos_t             dr_val [POT_N];

    assign dc       = decode(cmd_byte);
    assign busy     = recall_q | tmr_busy;
    assign acc_cmd  = cmd_valid  & ~busy;
    assign acc_dat  = dat_valid  & ~busy;
    assign acc_stop = stop_seen  & ~busy;
    assign acc_step = step_valid & ~busy;
    assign commit   = acc_stop & (pend_kind != PK_NONE) & wp_n;

    always_ff @(posedge clk) begin
        if (rst) recall_q <= 1'b1;
        else     recall_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            cur_v     <= 1'b0;
            cur_wrw   <= 1'b0;
            cur_wrd   <= 1'b0;
            cur_pi    <= '0;
            cur_ri    <= '0;
            step_on   <= 1'b0;
            step_pi   <= '0;
            pend_kind <= PK_NONE;
            pend_mask <= '0;
            pend_ri   <= '0;
            pend_val  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (acc_cmd) begin
                cur_v     <= 1'b1;
                cur_wrw   <= dc.wr_w;
                cur_wrd   <= dc.wr_d;
                cur_pi    <= dc.pi;
                cur_ri    <= dc.ri;
                step_on   <= dc.step;
                step_pi   <= dc.pi;
                pend_kind <= PK_NONE;
                if (dc.store || dc.gstore) begin
                    pend_kind <= PK_WIPER;
                    pend_ri   <= dc.ri;
                    pend_mask <= dc.gstore ? '1 : (POT_N'(1) << dc.pi);
                end
                if (dc.rd_w) begin
                    rd_valid <= 1'b1;
                    rd_data  <= wip[dc.pi];
                end
                if (dc.rd_d) begin
                    rd_valid <= 1'b1;
                    rd_data  <= drs[dc.pi][dc.ri];
                end
            end else if (acc_dat) begin
                cur_v     <= 1'b0;
                pend_kind <= PK_NONE;
                if (cur_v && cur_wrd) begin
                    pend_kind <= PK_VALUE;
                    pend_ri   <= cur_ri;
                    pend_val  <= dat_val;
                    pend_mask <= POT_N'(1) << cur_pi;
                end
            end else if (start_seen || acc_stop) begin
                cur_v     <= 1'b0;
                step_on   <= 1'b0;
                pend_kind <= PK_NONE;
            end
        end
    end

    for (genvar p = 0; p < POT_N; p++) begin : g_chan
        assign wl_en[p] = (acc_cmd && ((dc.load && dc.pi == PW'(p)) || dc.gload)) ||
                          (acc_dat && cur_v && cur_wrw && cur_pi == PW'(p));
        assign wl_val[p]  = acc_cmd ? drs[p][dc.ri] : dat_val;
        assign step_en[p] = acc_step && step_on && step_pi == PW'(p);
        assign dr_we[p]   = commit && pend_mask[p];
        assign dr_val[p]  = (pend_kind == PK_WIPER) ? wip[p] : pend_val;
        assign wiper_pos[p*WB +: WB] = wip[p];

        qpot_chan #(.PIDX(p), .BASE(DR_BASE)) chan_i (
            .clk       (clk),
            .rst       (rst),
            .recall_i  (recall_q),
            .wl_en_i   (wl_en[p]),
            .wl_val_i  (wl_val[p]),
            .step_en_i (step_en[p]),
            .step_up_i (step_up),
            .dr_we_i   (dr_we[p]),
            .dr_sel_i  (pend_ri),
            .dr_val_i  (dr_val[p]),
            .wiper_o   (wip[p]),
            .dr_o      (drs[p]),
            .wload_o   (wload[p])
        );
    end

    assign wiper_load = wload;

    qpot_nvtimer #(.WR_CYCLES(WR_CYCLES)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (commit),
        .busy_o  (tmr_busy)
    );
endmodule

// File: rtl/qpot_cmd_exec_chk.sv
module qpot_cmd_exec_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       step_valid,
    input logic       stop_seen,
    input logic       wp_n,
    input logic       rd_valid,
    input logic       busy,
    input logic [3:0] wiper_load
);
    logic undef_op;
    assign undef_op = (cmd_op == 4'b0000) || (cmd_op == 4'b1111) ||
                      (cmd_op >= 4'b0011 && cmd_op <= 4'b0111);

    assert_recall_busy_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy);

    assert_rd_source_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(cmd_valid) && !$past(busy)));

    assert_busy_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(stop_seen) && $past(wp_n)));

    assert_wp_block_R9: assert property (@(posedge clk) disable iff (rst)
        (stop_seen && !wp_n && !busy) |=> !busy);

    assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rd_valid);

    assert_undef_noop_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && !step_valid && undef_op) |=> (!rd_valid && wiper_load == 4'b0000));
endmodule

bind qpot_cmd_exec qpot_cmd_exec_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_byte[7:4]),
    .step_valid (step_valid),
    .stop_seen  (stop_seen),
    .wp_n       (wp_n),
    .rd_valid   (rd_valid),
    .busy       (busy),
    .wiper_load (wiper_load)
);

// File: tb/qpot_cmd_exec_tb_top.sv
module qpot_cmd_exec_tb_top;
    localparam int         WRC  = 20;
    localparam logic [5:0] BASE = 6'd60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0, dat_valid = 1'b0, step_valid = 1'b0, step_up = 1'b0;
    logic       start_seen = 1'b0, stop_seen = 1'b0, wp_n = 1'b1;
    logic [7:0] cmd_byte = '0;
    logic [5:0] dat_val = '0;
    logic       rd_valid, busy;
    logic [5:0] rd_data;
    logic [23:0] wiper_pos;
    logic [3:0] wiper_load;

    int n_chk = 0;
    int n_err = 0;
    logic [5:0] exp_q[$];
    string      tag_q[$];
    logic [5:0] ew [4];
    logic [5:0] ed [4][4];

    always #5 clk = ~clk;

    qpot_cmd_exec #(.WR_CYCLES(WRC), .DR_BASE(BASE)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .dat_valid(dat_valid), .dat_val(dat_val), .step_valid(step_valid),
        .step_up(step_up), .start_seen(start_seen), .stop_seen(stop_seen),
        .wp_n(wp_n), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .wiper_pos(wiper_pos), .wiper_load(wiper_load)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected read value per rd_valid
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11/R12 unexpected read data", rd_data, -1);
            end else begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    function automatic logic [7:0] ib(input logic [3:0] op, input int r, input int p);
        return {op, 2'(r), 2'(p)};
    endfunction
    function automatic logic [5:0] wpos(input int p);
        return wiper_pos[p*6 +: 6];
    endfunction

    task automatic do_start; @(negedge clk); start_seen = 1; @(negedge clk); start_seen = 0; endtask
    task automatic do_stop;  @(negedge clk); stop_seen = 1;  @(negedge clk); stop_seen = 0;  endtask
    task automatic do_cmd(input logic [7:0] b);
        @(negedge clk); cmd_valid = 1; cmd_byte = b; @(negedge clk); cmd_valid = 0;
    endtask
    task automatic do_dat(input logic [5:0] v);
        @(negedge clk); dat_valid = 1; dat_val = v; @(negedge clk); dat_valid = 0;
    endtask
    task automatic do_step(input logic up);
        @(negedge clk); step_valid = 1; step_up = up; @(negedge clk); step_valid = 0;
    endtask
    task automatic rd(input logic [7:0] b, input logic [5:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        do_start; do_cmd(b); do_stop;
    endtask
    task automatic wait_idle;
        while (busy) @(negedge clk);
    endtask
    task automatic chk_wipers(input string tag);
        for (int p = 0; p < 4; p++) check(wpos(p) == ew[p], tag, wpos(p), ew[p]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int n;
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) ed[p][r] = BASE + 6'(5 * p + r);
        for (int p = 0; p < 4; p++) ew[p] = ed[p][0];

        repeat (4) @(negedge clk);
        rst = 0;
        #1 check(busy == 1'b1, "R1 busy during recall", busy, 1);
        @(negedge clk);
        check(busy == 1'b0, "R1 busy clears after recall", busy, 0);
        chk_wipers("R1 wipers recalled from register 0");

        rd(ib(4'b1011, 3, 3), ed[3][3], "R4/R1 read p3 r3 wrapped init");
        rd(ib(4'b1011, 1, 2), ed[2][1], "R4 read p2 r1");
        rd(ib(4'b1001, 0, 1), ew[1], "R2 read wiper p1");

        // R3 wiper write
        do_start; do_cmd(ib(4'b1010, 0, 3)); do_dat(6'h25);
        ew[3] = 6'h25;
        check(wiper_load == 4'b1000, "R3 wiper_load only p3", wiper_load, 8);
        check(wpos(3) == 6'h25, "R3 wiper p3 written", wpos(3), 6'h25);
        do_stop;
        check(busy == 1'b0, "R3 no busy after wiper-only write", busy, 0);

        // R5 data register write and busy window
        do_start; do_cmd(ib(4'b1100, 2, 1)); do_dat(6'd7); do_stop;
        ed[1][2] = 6'd7;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check(n == WRC, "R5 busy window length", n, WRC);
        rd(ib(4'b1011, 2, 1), 6'd7, "R5 read back written register");

        // R6 store, with R11 strobes during busy
        do_start; do_cmd(ib(4'b1110, 1, 3)); do_stop;
        ed[3][1] = ew[3];
        check(busy == 1'b1, "R6 store raises busy", busy, 1);
        do_cmd(ib(4'b1101, 0, 3));
        check(wiper_load == 4'b0000, "R11 load ignored while busy", wiper_load, 0);
        check(wpos(3) == ew[3], "R11 wiper unchanged while busy", wpos(3), ew[3]);
        do_cmd(ib(4'b1001, 0, 0));
        check(rd_valid == 1'b0, "R11 read ignored while busy", rd_valid, 0);
        wait_idle;
        rd(ib(4'b1011, 1, 3), 6'h25, "R6 stored wiper in p3 r1");

        // R6 transfer register to wiper
        do_start; do_cmd(ib(4'b1101, 2, 0));
        ew[0] = ed[0][2];
        check(wiper_load == 4'b0001, "R6 load pulse p0", wiper_load, 1);
        check(wpos(0) == ed[0][2], "R6 wiper p0 from r2", wpos(0), ed[0][2]);
        do_stop;

        // R7 global recall
        do_start; do_cmd(ib(4'b0001, 1, 0));
        for (int p = 0; p < 4; p++) ew[p] = ed[p][1];
        check(wiper_load == 4'b1111, "R7 global load pulses", wiper_load, 15);
        chk_wipers("R7 global recall r1");
        do_stop;

        // R8 step mode and saturation
        do_start; do_cmd(ib(4'b1010, 0, 2)); do_dat(6'd62); do_stop;
        do_start; do_cmd(ib(4'b0010, 0, 2));
        repeat (3) do_step(1'b1);
        check(wpos(2) == 6'd63, "R8 step up saturates at 63", wpos(2), 63);
        do_step(1'b0);
        check(wpos(2) == 6'd62, "R8 step down by one", wpos(2), 62);
        do_stop;
        do_step(1'b1);
        check(wpos(2) == 6'd62 && wiper_load == 4'b0000, "R8 step ignored after stop", wpos(2), 62);
        do_start; do_cmd(ib(4'b1010, 0, 2)); do_dat(6'd1); do_stop;
        do_start; do_cmd(ib(4'b0010, 0, 2));
        repeat (2) do_step(1'b0);
        check(wpos(2) == 6'd0, "R8 step down saturates at 0", wpos(2), 0);
        do_stop;
        ew[2] = 6'd0;

        // R9 write protect
        wp_n = 1'b0;
        do_start; do_cmd(ib(4'b1100, 3, 0)); do_dat(6'd11); do_stop;
        check(busy == 1'b0, "R9 no busy under write protect", busy, 0);
        do_start; do_cmd(ib(4'b1010, 0, 0)); do_dat(6'd9); do_stop;
        ew[0] = 6'd9;
        check(wpos(0) == 6'd9, "R9 wiper write under protect", wpos(0), 9);
        wp_n = 1'b1;
        rd(ib(4'b1011, 3, 0), ed[0][3], "R9 protected register unchanged");

        // R10 abort by repeated start
        do_start; do_cmd(ib(4'b1100, 0, 2)); do_dat(6'd50); do_start; do_stop;
        check(busy == 1'b0, "R10 aborted write no busy", busy, 0);
        rd(ib(4'b1011, 0, 2), ed[2][0], "R10 aborted write left register");

        // R7 global store
        do_start; do_cmd(ib(4'b1000, 2, 0)); do_stop;
        for (int p = 0; p < 4; p++) ed[p][2] = ew[p];
        check(busy == 1'b1, "R7 global store raises busy", busy, 1);
        wait_idle;
        for (int p = 0; p < 4; p++) rd(ib(4'b1011, 2, p), ed[p][2], "R7 global store read back");

        // R12 undefined opcodes
        do_start; do_cmd(8'h55);
        check(wiper_load == 4'b0000 && rd_valid == 1'b0, "R12 opcode 0101 no effect", wiper_load, 0);
        do_stop;
        do_start; do_cmd(8'hF3);
        check(wiper_load == 4'b0000 && rd_valid == 1'b0, "R12 opcode 1111 no effect", wiper_load, 0);
        do_stop;
        check(busy == 1'b0, "R12 no busy after undefined", busy, 0);
        chk_wipers("R12 wipers unchanged");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2/R4 all expected reads seen", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule